// File: doc/BRIEF.md
# SCSI Command Descriptor Length Detector

This block runs on the target side while the bus is in Command Phase. The host starts it with a one-cycle command pulse. The block then waits for the first command byte from the initiator. From the top three bits of that byte (the group code) it works out how long the whole command descriptor is. It loads a transfer counter with the number of bytes still to come, and it raises a flag that tells whether the group code was recognised. Each later byte is passed on and counts the counter down. When the counter reaches zero the command ends successfully.

Two events end the command early. If the initiator asserts attention, the block raises a service-request pulse and returns to idle. If a byte arrives with a parity error, the block raises a parity-abort pulse and returns to idle. The received bytes leave the block through a registered strobe and data pair. Completion, service request and parity abort are single-cycle pulses that the surrounding status logic records.

Top module: `cdb_len_detect`

## Requirements
- R1: After reset, `cmd_active`, `rx_valid`, `gcv`, `done_ok`, `svc_req` and `perr_abort` are 0, and `xfer_count` is 0.
- R2: A `start` pulse while idle makes `cmd_active` 1 from the next cycle on. The block then takes the first byte accepted as the command's first byte.
- R3: The group code is bits 7:5 of the first byte. Group 0 loads `xfer_count` with 5, groups 1 and 2 load it with 9, and group 5 loads it with 11. In each of these cases `gcv` becomes 1. The count is the descriptor length minus the first byte.
- R4: Group codes 3, 4, 6 and 7 load `xfer_count` with 5 and set `gcv` to 0.
- R5: Every byte accepted while active appears on `rx_data`, with `rx_valid` high for one cycle, in the cycle after it is offered. Every accepted byte after the first lowers `xfer_count` by 1.
- R6: The cycle in which `xfer_count` reaches 0 shows `done_ok` high for one cycle, together with the last byte on `rx_valid` and `cmd_active` at 0.
- R7: `atn` high while active makes `svc_req` high for one cycle on the next cycle and clears `cmd_active`. A byte offered in the same cycle is not forwarded, `xfer_count` keeps its value and `done_ok` stays 0.
- R8: A byte with `rx_perr` set while active makes `perr_abort` high for one cycle on the next cycle and clears `cmd_active`. The byte is not forwarded, and `xfer_count` and `gcv` keep their values.
- R9: Bytes offered while idle are not forwarded and change neither `xfer_count` nor `gcv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command issue pulse |
| rx_strobe | input | 1 | A received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error flag for the offered byte |
| atn | input | 1 | Attention from the initiator |
| cmd_active | output | 1 | A command is in progress |
| xfer_count | output | 16 | Bytes still expected |
| gcv | output | 1 | The last group code was recognised |
| rx_valid | output | 1 | Forwarded byte strobe |
| rx_data | output | 8 | Forwarded byte |
| done_ok | output | 1 | Successful completion pulse |
| svc_req | output | 1 | Attention-termination pulse |
| perr_abort | output | 1 | Parity-termination pulse |

## Verification
A wrong state shows at the ports within one cycle. If the controller is stuck in the first-byte state, every later byte reloads the counter, so `xfer_count` no longer falls by one. If the counter is wrong, `done_ok` comes one byte too early or too late and `cmd_active` drops at the wrong byte. If a group is decoded wrongly, the bad value appears in `xfer_count` and `gcv` in the cycle after the first byte. The bench tries every group code and then checks each forwarded byte, the count after each byte, and the exact byte on which the command ends.

// File: rtl/cdbl_pkg.sv
package cdbl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_REST  = 2'd2
  } cdbl_state_e;

  typedef struct packed {
    logic       known;
    logic [4:0] total;
  } grp_len_t;

  function automatic grp_len_t grp_lookup(input logic [2:0] grp);
    grp_len_t r;
    r.known = 1'b1;
    case (grp)
      3'd0:    r.total = 5'd6;
      3'd1:    r.total = 5'd10;
      3'd2:    r.total = 5'd10;
      3'd5:    r.total = 5'd12;
      default: begin
        r.known = 1'b0;
        r.total = 5'd0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cdbl_group_decode.sv
module cdbl_group_decode #(
  parameter int CNT_W       = 16,
  parameter int DEFAULT_REM = 5
) (
  input  logic [2:0]       grp,
  output logic             known,
  output logic [CNT_W-1:0] rem
);
  import cdbl_pkg::*;

  grp_len_t lk;

  always_comb begin
    lk    = grp_lookup(grp);
    known = lk.known;
    if (lk.known) begin
      rem = CNT_W'(lk.total) - CNT_W'(1);
    end else begin
      rem = CNT_W'(DEFAULT_REM);
    end
  end

endmodule

// File: rtl/cdbl_xfer_cnt.sv
module cdbl_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] count,
  output logic             count_is_one
);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en) begin
      cnt_d = load_val;
    end else if (dec_en) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_en || dec_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count        = cnt_q;
  assign count_is_one = (cnt_q == CNT_W'(1));

  // R5: the controller never counts below zero
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (cnt_q != '0));

endmodule

// File: rtl/cdbl_ctrl.sv
module cdbl_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rx_strobe,
  input  logic rx_perr,
  input  logic atn,
  input  logic count_is_one,
  output logic load_en,
  output logic dec_en,
  output logic fwd_en,
  output logic cmd_active,
  output logic done_ok,
  output logic svc_req,
  output logic perr_abort
);
  import cdbl_pkg::*;

  cdbl_state_e state_d, state_q;
  logic done_d, svc_d, perr_d;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    dec_en  = 1'b0;
    fwd_en  = 1'b0;
    done_d  = 1'b0;
    svc_d   = 1'b0;
    perr_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) state_d = ST_FIRST;
      end
      ST_FIRST, ST_REST: begin
        if (atn) begin
          svc_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (rx_strobe) begin
          if (rx_perr) begin
            perr_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            fwd_en = 1'b1;
            if (state_q == ST_FIRST) begin
              load_en = 1'b1;
              state_d = ST_REST;
            end else begin
              dec_en = 1'b1;
              if (count_is_one) begin
                done_d  = 1'b1;
                state_d = ST_IDLE;
              end
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      done_ok    <= 1'b0;
      svc_req    <= 1'b0;
      perr_abort <= 1'b0;
    end else begin
      state_q    <= state_d;
      done_ok    <= done_d;
      svc_req    <= svc_d;
      perr_abort <= perr_d;
    end
  end

  assign cmd_active = (state_q != ST_IDLE);

  // R6 R7 R8: at most one way of ending per cycle
  assert_single_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, svc_req, perr_abort}));

  // R7: attention leaves the block idle
  assert_atn_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> !cmd_active);

  // R8: parity abort leaves the block idle
  assert_perr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    perr_abort |-> !cmd_active);

endmodule

// File: rtl/cdb_len_detect.sv
module cdb_len_detect #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int DEFAULT_REM = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_perr,
  input  logic              atn,
  output logic              cmd_active,
  output logic [CNT_W-1:0]  xfer_count,
  output logic              gcv,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_ok,
  output logic              svc_req,
  output logic              perr_abort
);

  localparam int GRP_LSB = DATA_W - 3;

  logic             load_en, dec_en, fwd_en, count_is_one;
  logic             grp_known;
  logic [CNT_W-1:0] grp_rem;
  logic             gcv_q;
  logic             rxv_q;
  logic [DATA_W-1:0] rxd_q;

  cdbl_group_decode #(.CNT_W(CNT_W), .DEFAULT_REM(DEFAULT_REM)) u_dec (
    .grp   (rx_byte[DATA_W-1:GRP_LSB]),
    .known (grp_known),
    .rem   (grp_rem)
  );

  cdbl_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_en      (load_en),
    .load_val     (grp_rem),
    .dec_en       (dec_en),
    .count        (xfer_count),
    .count_is_one (count_is_one)
  );

  cdbl_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rx_strobe    (rx_strobe),
    .rx_perr      (rx_perr),
    .atn          (atn),
    .count_is_one (count_is_one),
    .load_en      (load_en),
    .dec_en       (dec_en),
    .fwd_en       (fwd_en),
    .cmd_active   (cmd_active),
    .done_ok      (done_ok),
    .svc_req      (svc_req),
    .perr_abort   (perr_abort)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcv_q <= 1'b0;
    end else if (load_en) begin
      gcv_q <= grp_known;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxv_q <= 1'b0;
    end else begin
      rxv_q <= fwd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= '0;
    end else if (fwd_en) begin
      rxd_q <= rx_byte;
    end
  end

  assign gcv      = gcv_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

  // R4: an unrecognised group always leaves the default count
  assert_default_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (gcv || (xfer_count == CNT_W'(DEFAULT_REM))));

  // R6: success only once nothing is left to receive
  assert_done_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (xfer_count == '0 && rx_valid));

  // R9: no forwarding while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_active && rx_strobe) |=> !rx_valid);

endmodule

// File: tb/cdb_len_detect_tb_top.sv
module cdb_len_detect_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, rx_strobe, rx_perr, atn;
  logic [7:0]  rx_byte;
  logic        cmd_active, gcv, rx_valid, done_ok, svc_req, perr_abort;
  logic [15:0] xfer_count;
  logic [7:0]  rx_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cdb_len_detect dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .rx_perr(rx_perr), .atn(atn),
    .cmd_active(cmd_active), .xfer_count(xfer_count), .gcv(gcv),
    .rx_valid(rx_valid), .rx_data(rx_data), .done_ok(done_ok),
    .svc_req(svc_req), .perr_abort(perr_abort)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // present one cycle of stimulus, then sample after the edge
  task automatic cycle(input bit s, input bit v, input logic [7:0] d,
                       input bit p, input bit a);
    @(negedge clk);
    start = s; rx_strobe = v; rx_byte = d; rx_perr = p; atn = a;
    @(negedge clk);
    start = 0; rx_strobe = 0; rx_perr = 0; atn = 0;
  endtask

  function automatic int exp_rem(input int g);
    case (g)
      0: return 5;
      1, 2: return 9;
      5: return 11;
      default: return 5;
    endcase
  endfunction

  function automatic bit exp_known(input int g);
    return (g == 0 || g == 1 || g == 2 || g == 5);
  endfunction

  initial begin
    #1500000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    start = 0; rx_strobe = 0; rx_byte = 0; rx_perr = 0; atn = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1 cmd_active", cmd_active, 0);
    chk_eq("R1 xfer_count", xfer_count, 0);
    chk_eq("R1 gcv", gcv, 0);
    chk_eq("R1 flags", {rx_valid, done_ok, svc_req, perr_abort}, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 idle bytes ignored
    cycle(0, 1, 8'h20, 0, 0);
    chk_eq("R9 no forward", rx_valid, 0);
    chk_eq("R9 count kept", xfer_count, 0);
    chk_eq("R9 gcv kept", gcv, 0);

    // R3 R4 R5 R6 sweep over all groups and several low-bit patterns
    for (int g = 0; g < 8; g++) begin
      for (int lo = 0; lo < 32; lo += 11) begin
        automatic logic [7:0] fb = {3'(g), 5'(lo)};
        automatic int rem = exp_rem(g);
        cycle(1, 0, 8'h00, 0, 0);
        chk_eq("R2 active after start", cmd_active, 1);
        cycle(0, 1, fb, 0, 0);
        chk_eq("R3 R4 count load", xfer_count, rem);
        chk_eq("R3 R4 gcv", gcv, exp_known(g));
        chk_eq("R5 first forwarded", {rx_valid, rx_data}, {1'b1, fb});
        for (int k = 1; k <= rem; k++) begin
          automatic logic [7:0] b = 8'(g * 37 + k * 13 + lo);
          cycle(0, 1, b, 0, 0);
          chk_eq("R5 byte forwarded", {rx_valid, rx_data}, {1'b1, b});
          chk_eq("R5 count step", xfer_count, rem - k);
          chk_eq("R6 done timing", done_ok, (k == rem) ? 1 : 0);
          chk_eq("R6 active", cmd_active, (k == rem) ? 0 : 1);
        end
        cycle(0, 0, 8'h00, 0, 0);
        chk_eq("R6 done one cycle", done_ok, 0);
      end
    end

    // R7 attention mid-transfer, with a byte in the same cycle
    cycle(1, 0, 8'h00, 0, 0);
    cycle(0, 1, 8'h21, 0, 0);
    cycle(0, 1, 8'h55, 0, 0);
    cycle(0, 1, 8'h66, 0, 1);
    chk_eq("R7 svc_req", svc_req, 1);
    chk_eq("R7 not forwarded", rx_valid, 0);
    chk_eq("R7 count kept", xfer_count, 8);
    chk_eq("R7 inactive", cmd_active, 0);
    chk_eq("R7 no done", done_ok, 0);
    cycle(0, 0, 8'h00, 0, 0);
    chk_eq("R7 pulse one cycle", svc_req, 0);

    // R7 attention before the first byte
    cycle(1, 0, 8'h00, 0, 0);
    cycle(0, 0, 8'h00, 0, 1);
    chk_eq("R7 early svc", {svc_req, cmd_active}, 2'b10);

    // R8 parity on first byte: gcv and count untouched (gcv=1 from group 1)
    cycle(1, 0, 8'h00, 0, 0);
    cycle(0, 1, 8'hE0, 1, 0);
    chk_eq("R8 perr pulse", perr_abort, 1);
    chk_eq("R8 not forwarded", rx_valid, 0);
    chk_eq("R8 gcv kept", gcv, 1);
    chk_eq("R8 count kept", xfer_count, 8);
    chk_eq("R8 inactive", cmd_active, 0);

    // R8 parity mid-transfer
    cycle(1, 0, 8'h00, 0, 0);
    cycle(0, 1, 8'hA3, 0, 0);
    cycle(0, 1, 8'h11, 0, 0);
    cycle(0, 1, 8'h12, 1, 0);
    chk_eq("R8 mid perr", {perr_abort, rx_valid, cmd_active}, 3'b100);
    chk_eq("R8 mid count", xfer_count, 10);
    cycle(0, 0, 8'h00, 0, 0);
    chk_eq("R8 pulse one cycle", perr_abort, 0);

    // R9 idle after abort
    cycle(0, 1, 8'h00, 0, 0);
    chk_eq("R9 idle after abort", {rx_valid, xfer_count}, {1'b0, 16'd10});

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule